// File: doc/BRIEF.md
# Decimal-capable 8-bit accumulator arithmetic unit

This block does the arithmetic of a classic 8-bit accumulator processor. Each cycle it takes the accumulator, an operand, the incoming carry, the decimal-mode flag, the current overflow flag and a 2-bit operation code. It produces the new result byte and the negative, zero, carry and overflow flags. There are four operations: add with carry, subtract with borrow, unsigned compare, and operand pass-through. Add and subtract each work in plain binary or in packed two-digit BCD.

In decimal mode the flags follow the behaviour of the early NMOS silicon, not the corrected BCD value. For an add, the zero flag looks at the plain binary sum. The negative and overflow flags come from the sum after only the low digit has been fixed up. For a subtract, all of N, Z and V come from the binary difference. Software that tests these flags after decimal arithmetic sees exactly the values the original part gave.

The arithmetic is combinational. A parameter chooses between a registered output stage and a direct combinational path. When the output is registered, a valid strobe comes out one cycle after the input strobe, and the outputs hold their value between strobes.

Top module: `bcd_alu_unit`

## Requirements
- R1: Binary add (op code 00, decimal flag 0) forms S = A + B + Cin. The result is S mod 256 and C is bit 8 of S. N is bit 7 of the result and Z is set when the result is zero. V is bit 7 of (~(A^B) & (A^result)).
- R2: Decimal add (op code 00, decimal flag 1) first forms the low-digit sum L = A[3:0] + B[3:0] + Cin. When L >= 10, the full sum gets +6 if L < 26 and -10 otherwise. If the adjusted sum is 0xA0 or more, C is 1 and the result is (adjusted + 0x60) mod 256. Otherwise C is 0 and the result is the adjusted sum.
- R3: In a decimal add, Z is set when (A + B + Cin) mod 256 is zero. N is bit 7 of the adjusted sum from R2, and V is bit 7 of (~(A^B) & (A^adjusted)).
- R4: Subtract (op code 01) forms D = A - B - 1 + Cin. C is 1 exactly when D >= 0. N, Z and V always come from D mod 256, with V being bit 7 of ((A^B) & (A^D)). In binary mode the result is D mod 256.
- R5: In a decimal subtract, the low-digit difference is A[3:0] - B[3:0] - 1 + Cin. If it is negative, the binary result is changed by +10 when that difference is below -10, and by -6 otherwise. If C is 0, a further 0x60 is then subtracted. All of this is mod 256.
- R6: Compare (op code 10) sets C when A >= B unsigned. N and Z come from (A - B) mod 256. The result output carries A unchanged. V equals the overflow input. Neither the decimal flag nor Cin has any effect.
- R7: Pass (op code 11) puts B on the result and sets N and Z from B. C equals Cin and V equals the overflow input.
- R8: With the output register enabled, the outputs take the new values on the clock edge where the input strobe is high. The valid output is high for exactly the cycle after each strobed cycle. With the strobe low, all outputs keep their value.
- R9: While reset is asserted (active low), the result and all four flags are 0 and the valid output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input strobe; operands are taken on this cycle |
| acc_i | input | 8 | Accumulator (or register under compare) |
| opnd_i | input | 8 | Operand byte |
| carry_i | input | 1 | Incoming carry flag |
| dec_i | input | 1 | Decimal-mode flag |
| ovf_i | input | 1 | Current overflow flag, kept by compare and pass |
| op_sel_i | input | 2 | 00 add, 01 subtract, 10 compare, 11 pass |
| result_o | output | 8 | Result byte |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Overflow flag |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |

## Verification
The bench targets decimal adds whose corrected result is 0x00 while the raw sum is not. A design that took Z or N from the corrected byte would report Z=1, N=0 for 0x99+0x01 instead of Z=0, N=1. It checks the reverse case, 0x99+0x67, where only the raw sum is zero. It also drives low-digit sums above 25, which a design adding a fixed 6 would turn into the wrong digit. For subtracts, it drives a low-digit borrow below -10, and a borrow out of the whole byte that needs the extra 0x60 correction. Finally, it feeds compare with decimal mode and carry set, and it changes the inputs with the strobe low. A leaky register would show up as a changed result.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_PASS = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              n;
    logic              z;
    logic              c;
    logic              v;
  } alu_out_t;

  function automatic logic ovf_of_add(input logic [BYTE_W-1:0] a,
                                      input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] t;
    t = ~(a ^ b) & (a ^ s);
    return t[BYTE_W-1];
  endfunction

  function automatic logic ovf_of_sub(input logic [BYTE_W-1:0] a,
                                      input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] t;
    t = (a ^ b) & (a ^ d);
    return t[BYTE_W-1];
  endfunction

  function automatic logic is_zero(input logic [BYTE_W-1:0] x);
    return (x == '0);
  endfunction

endpackage

// File: rtl/bcd_add_path.sv
module bcd_add_path
  import bcd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              dec_i,
  output alu_out_t          out_o
);

  localparam int SUM_W = BYTE_W + 2;
  localparam logic [NIB_W:0]   NIB_TEN   = 10;
  localparam logic [NIB_W:0]   NIB_WRAP  = 26;
  localparam logic [SUM_W-1:0] DEC_LIMIT = 10'h0A0;

  logic [SUM_W-1:0] raw_sum;
  logic [SUM_W-1:0] adj_sum;
  logic [NIB_W:0]   nib_sum;
  logic             nib_fix;

  always_comb begin
    raw_sum = {2'b00, a_i} + {2'b00, b_i} + {{(SUM_W-1){1'b0}}, cin_i};
    nib_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    nib_fix = dec_i && (nib_sum >= NIB_TEN);
    adj_sum = raw_sum;
    if (nib_fix)
      adj_sum = (nib_sum < NIB_WRAP) ? raw_sum + 10'd6 : raw_sum - 10'd10;
  end

  always_comb begin
    out_o.z = is_zero(raw_sum[BYTE_W-1:0]);
    out_o.n = adj_sum[BYTE_W-1];
    out_o.v = ovf_of_add(a_i, b_i, adj_sum[BYTE_W-1:0]);
    if (!dec_i) begin
      out_o.res = raw_sum[BYTE_W-1:0];
      out_o.c   = raw_sum[BYTE_W];
    end else if (adj_sum >= DEC_LIMIT) begin
      out_o.res = adj_sum[BYTE_W-1:0] + 8'h60;
      out_o.c   = 1'b1;
    end else begin
      out_o.res = adj_sum[BYTE_W-1:0];
      out_o.c   = 1'b0;
    end
  end

  // R1
  add_bin_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_i |-> ({out_o.c, out_o.res} == ({1'b0, a_i} + {1'b0, b_i} + {8'd0, cin_i})));

  // R3
  add_dec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (out_o.z == ((a_i + b_i + {7'd0, cin_i}) == 8'd0)));

  // R2
  add_dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !out_o.c) |-> (out_o.res < 8'hA0));

endmodule

// File: rtl/bcd_sub_path.sv
module bcd_sub_path
  import bcd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              dec_i,
  output alu_out_t          out_o
);

  localparam int DIF_W = BYTE_W + 2;
  localparam int NDF_W = NIB_W + 2;

  logic [DIF_W-1:0] diff;
  logic [NDF_W-1:0] nib_diff;
  logic             nib_borrow;
  logic             nib_deep;
  logic             no_borrow;
  logic [BYTE_W-1:0] fixed;

  always_comb begin
    diff     = {2'b00, a_i} - {2'b00, b_i} - 10'd1 + {{(DIF_W-1){1'b0}}, cin_i};
    nib_diff = {2'b00, a_i[NIB_W-1:0]} - {2'b00, b_i[NIB_W-1:0]} - 6'd1
               + {{(NDF_W-1){1'b0}}, cin_i};
    nib_borrow = nib_diff[NDF_W-1];
    nib_deep   = ($signed(nib_diff) < -6'sd10);
    no_borrow  = ~diff[DIF_W-1];
    fixed = diff[BYTE_W-1:0];
    if (dec_i) begin
      if (nib_borrow)
        fixed = nib_deep ? fixed + 8'd10 : fixed - 8'd6;
      if (!no_borrow)
        fixed = fixed - 8'h60;
    end
  end

  always_comb begin
    out_o.res = fixed;
    out_o.c   = no_borrow;
    out_o.n   = diff[BYTE_W-1];
    out_o.z   = is_zero(diff[BYTE_W-1:0]);
    out_o.v   = ovf_of_sub(a_i, b_i, diff[BYTE_W-1:0]);
  end

  // R4
  sub_bin_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_i |-> (out_o.res == (a_i - b_i - {7'd0, ~cin_i})));

  // R4
  sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_o.c == ({1'b0, a_i} >= ({1'b0, b_i} + {8'd0, ~cin_i})));

endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage
  import bcd_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  alu_out_t          nxt_i,
  output logic [BYTE_W-1:0] result_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              out_valid_o
);

  alu_out_t held;

  generate
    if (REG_OUT) begin : g_reg
      logic vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held  <= '0;
          vld_q <= 1'b0;
        end else begin
          vld_q <= in_valid_i;
          if (in_valid_i)
            held <= nxt_i;
        end
      end
      assign out_valid_o = vld_q;

      // R8
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

      // R8
      hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(result_o) && $stable(carry_o) && !out_valid_o));
    end else begin : g_comb
      assign held        = nxt_i;
      assign out_valid_o = in_valid_i;
    end
  endgenerate

  assign result_o = held.res;
  assign neg_o    = held.n;
  assign zero_o   = held.z;
  assign carry_o  = held.c;
  assign ovf_o    = held.v;

endmodule

// File: rtl/bcd_alu_unit.sv
module bcd_alu_unit
  import bcd_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       carry_i,
  input  logic       dec_i,
  input  logic       ovf_i,
  input  logic [1:0] op_sel_i,
  output logic [7:0] result_o,
  output logic       neg_o,
  output logic       zero_o,
  output logic       carry_o,
  output logic       ovf_o,
  output logic       out_valid_o
);

  alu_op_e  op;
  alu_out_t add_out;
  alu_out_t sub_out;
  alu_out_t cmp_out;
  alu_out_t pass_out;
  alu_out_t nxt;
  logic [BYTE_W:0] cmp_diff;

  assign op = alu_op_e'(op_sel_i);

  bcd_add_path u_add (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (carry_i),
    .dec_i (dec_i),
    .out_o (add_out)
  );

  bcd_sub_path u_sub (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (carry_i),
    .dec_i (dec_i),
    .out_o (sub_out)
  );

  always_comb begin
    cmp_diff  = {1'b0, acc_i} - {1'b0, opnd_i};
    cmp_out.res = acc_i;
    cmp_out.c   = ~cmp_diff[BYTE_W];
    cmp_out.n   = cmp_diff[BYTE_W-1];
    cmp_out.z   = is_zero(cmp_diff[BYTE_W-1:0]);
    cmp_out.v   = ovf_i;

    pass_out.res = opnd_i;
    pass_out.n   = opnd_i[BYTE_W-1];
    pass_out.z   = is_zero(opnd_i);
    pass_out.c   = carry_i;
    pass_out.v   = ovf_i;
  end

  always_comb begin
    unique case (op)
      OP_ADD:  nxt = add_out;
      OP_SUB:  nxt = sub_out;
      OP_CMP:  nxt = cmp_out;
      default: nxt = pass_out;
    endcase
  end

  bcd_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .nxt_i       (nxt),
    .result_o    (result_o),
    .neg_o       (neg_o),
    .zero_o      (zero_o),
    .carry_o     (carry_o),
    .ovf_o       (ovf_o),
    .out_valid_o (out_valid_o)
  );

  // R6
  cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel_i == 2'b10) |-> (nxt.c == (acc_i >= opnd_i)));

  // R6
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel_i == 2'b10) |-> (nxt.z == (acc_i == opnd_i)));

  generate
    if (REG_OUT) begin : g_pass_chk
      // R7
      pass_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_sel_i == 2'b11) |=> (result_o == $past(opnd_i) && carry_o == $past(carry_i)));
    end
  endgenerate

endmodule

// File: tb/sim_bcd_alu_unit.sv
module sim_bcd_alu_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic       carry_i = 1'b0;
  logic       dec_i = 1'b0;
  logic       ovf_i = 1'b0;
  logic [1:0] op_sel_i = '0;
  logic [7:0] result_o;
  logic       neg_o, zero_o, carry_o, ovf_o, out_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_alu_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i), .dec_i(dec_i),
    .ovf_i(ovf_i), .op_sel_i(op_sel_i),
    .result_o(result_o), .neg_o(neg_o), .zero_o(zero_o),
    .carry_o(carry_o), .ovf_o(ovf_o), .out_valid_o(out_valid_o)
  );

  // {req[3:0], op[1:0], dec, cin, vin, a[7:0], b[7:0], res[7:0], nzcv[3:0]}
  localparam int NV = 22;
  localparam logic [36:0] VEC [NV] = '{
    {4'd1, 2'b00, 1'b0, 1'b0, 1'b0, 8'h50, 8'h50, 8'hA0, 4'b1001}, // R1
    {4'd1, 2'b00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 4'b0110}, // R1
    {4'd1, 2'b00, 1'b0, 1'b1, 1'b1, 8'h12, 8'h34, 8'h47, 4'b0000}, // R1
    {4'd2, 2'b00, 1'b1, 1'b0, 1'b0, 8'h15, 8'h27, 8'h42, 4'b0000}, // R2
    {4'd2, 2'b00, 1'b1, 1'b1, 1'b0, 8'h0F, 8'h0F, 8'h15, 4'b0000}, // R2 nibble >= 26
    {4'd2, 2'b00, 1'b1, 1'b1, 1'b0, 8'h58, 8'h46, 8'h05, 4'b1011}, // R2
    {4'd3, 2'b00, 1'b1, 1'b0, 1'b0, 8'h99, 8'h01, 8'h00, 4'b1010}, // R3
    {4'd3, 2'b00, 1'b1, 1'b0, 1'b0, 8'h50, 8'h50, 8'h00, 4'b1011}, // R3
    {4'd3, 2'b00, 1'b1, 1'b0, 1'b0, 8'h99, 8'h67, 8'h66, 4'b0110}, // R3
    {4'd4, 2'b01, 1'b0, 1'b1, 1'b0, 8'h50, 8'hB0, 8'hA0, 4'b1001}, // R4
    {4'd4, 2'b01, 1'b0, 1'b1, 1'b0, 8'h05, 8'h05, 8'h00, 4'b0110}, // R4
    {4'd4, 2'b01, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, 4'b1000}, // R4
    {4'd4, 2'b01, 1'b1, 1'b1, 1'b0, 8'h10, 8'h10, 8'h00, 4'b0110}, // R4 decimal flags
    {4'd5, 2'b01, 1'b1, 1'b1, 1'b0, 8'h42, 8'h15, 8'h27, 4'b0010}, // R5
    {4'd5, 2'b01, 1'b1, 1'b1, 1'b0, 8'h00, 8'h01, 8'h99, 4'b1000}, // R5
    {4'd5, 2'b01, 1'b1, 1'b0, 1'b0, 8'h00, 8'h0F, 8'h9A, 4'b1000}, // R5 below -10
    {4'd6, 2'b10, 1'b0, 1'b0, 1'b1, 8'h40, 8'h40, 8'h40, 4'b0111}, // R6
    {4'd6, 2'b10, 1'b1, 1'b1, 1'b0, 8'h10, 8'h20, 8'h10, 4'b1000}, // R6
    {4'd6, 2'b10, 1'b0, 1'b0, 1'b0, 8'h80, 8'h7F, 8'h80, 4'b0010}, // R6
    {4'd7, 2'b11, 1'b0, 1'b1, 1'b1, 8'h33, 8'h80, 8'h80, 4'b1011}, // R7
    {4'd7, 2'b11, 1'b1, 1'b0, 1'b0, 8'h33, 8'h00, 8'h00, 4'b0100}, // R7
    {4'd1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h7F, 8'h00, 8'h80, 4'b1001}  // R1
  };

  task automatic check(input int req, input string what,
                       input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check(9, "reset outputs", {3'b0, out_valid_o, result_o},
          12'h000);
    check(9, "reset flags", {8'h0, neg_o, zero_o, carry_o, ovf_o}, 12'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [36:0] e;
      e = VEC[i];
      @(negedge clk);
      op_sel_i   = e[32:31];
      dec_i      = e[30];
      carry_i    = e[29];
      ovf_i      = e[28];
      acc_i      = e[27:20];
      opnd_i     = e[19:12];
      in_valid_i = 1'b1;
      @(negedge clk);
      check(int'(e[36:33]), $sformatf("vector %0d result", i),
            {4'h0, result_o}, {4'h0, e[11:4]});
      check(int'(e[36:33]), $sformatf("vector %0d nzcv", i),
            {8'h0, neg_o, zero_o, carry_o, ovf_o}, {8'h0, e[3:0]});
    end

    // R8: valid strobe follows by one cycle, outputs hold while strobe low
    @(negedge clk);
    in_valid_i = 1'b0;
    op_sel_i = 2'b00; dec_i = 1'b0; carry_i = 1'b0;
    acc_i = 8'hEE; opnd_i = 8'hEE;
    check(8, "valid after strobe", {11'h0, out_valid_o}, 12'h001);
    @(negedge clk);
    check(8, "valid drops", {11'h0, out_valid_o}, 12'h000);
    check(8, "result held", {4'h0, result_o}, 12'h080);
    check(8, "flags held", {8'h0, neg_o, zero_o, carry_o, ovf_o}, 12'h009);
    repeat (3) @(negedge clk);
    check(8, "still held", {4'h0, result_o}, 12'h080);
    in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    check(8, "new result", {3'h0, out_valid_o, result_o}, 12'h1DC);
    @(negedge clk);
    check(8, "single pulse", {11'h0, out_valid_o}, 12'h000);

    // R9: reset clears again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(9, "reset clears", {3'b0, out_valid_o, result_o}, 12'h000);
    check(9, "reset clears flags", {8'h0, neg_o, zero_o, carry_o, ovf_o}, 12'h000);

    done = 1'b1;
    finish_run();
  end

endmodule